// File: doc/BRIEF.md
# Boot Source Lock-In Selector

This block sits between four byte-wide inbound link ports and a single boot-loader input. After reset it waits for the first port that offers data and locks onto that port. The whole boot stream is then taken from the chosen port alone. The other ports stay stalled and none of their data is consumed. A one-cycle release pulse drops the lock, and the block goes back to watching all four ports.

Every port and the output use a valid/ready handshake. Data moves when valid and ready are both high at a rising clock edge. The selected port's ready is wired straight to the output sink's ready, so the block holds no data of its own. A `configured` input gates all traffic. While it is low, every port sees ready low and its sender waits, so nothing is dropped while the surrounding logic is still being set up.

Simultaneous arrivals are settled by a rotating start pointer. The pointer counts up once per clock from zero at reset. The four port positions 0 to 3 carry the external link labels 0, 1, 3 and 4, in that order.

Top module: `boot_src_sel`

## Requirements
- R1: While reset is held, `locked` is 0, `sel_idx` is 0, `out_valid` is 0 and every bit of `in_ready` is 0.
- R2: While `configured` is 0, every `in_ready` bit is 0, `out_valid` is 0, and no lock is taken, whatever the ports present.
- R3: When unlocked and configured, with at least one `in_valid` bit set at a rising edge, the block locks at that edge. It selects the first valid port found by searching upward from the pointer position and wrapping from 3 to 0. The pointer is 0 at the first edge after reset and goes up by one, modulo 4, at every edge.
- R4: While unlocked, every `in_ready` bit is 0 and `out_valid` is 0. No data transfers during the scan.
- R5: While locked and configured, `out_valid` equals `in_valid` of the selected port, and `out_data` equals that port's byte. Port p's byte is `in_data[8p+7:8p]`. The selected port's `in_ready` equals `out_ready`.
- R6: While locked, the `in_ready` bit of every non-selected port is 0.
- R7: A high `release_lock` at an edge while locked clears `locked` at that edge. The next edge may lock again under R3. A high `release_lock` while unlocked has no effect.
- R8: If `configured` falls while locked, `out_valid` and all `in_ready` bits go to 0 while it stays low. The lock and `sel_idx` are kept.
- R9: While locked and no release is given, `locked` stays 1 and `sel_idx` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| configured | input | 1 | High once the surrounding logic is ready for traffic |
| release_lock | input | 1 | Pulse high to drop the lock |
| in_valid | input | 4 | Per-port valid, bit p is port position p |
| in_data | input | 32 | Per-port bytes, port p in bits 8p+7:8p |
| in_ready | output | 4 | Per-port ready |
| out_valid | output | 1 | Boot stream valid |
| out_data | output | 8 | Boot stream byte |
| out_ready | input | 1 | Boot stream sink ready |
| sel_idx | output | 2 | Position of the locked port |
| locked | output | 1 | High while a port is selected |

## Verification
Two functions can fall in the same cycle. The first pair is a release pulse and a new arrival: the release has to win at that edge, and the arrival is handled by the scan at the next edge. The second pair is a lock decision where several ports raise valid together. The bench provokes both by holding all or several ports valid across repeated lock/release rounds, so that the pointer meets each phase. It also adds a long random stretch in which release, configured, backpressure and valids all change freely. A behavioural model tracks the pointer and the lock per cycle and judges every output before each edge.

// File: rtl/boot_src_sel.sv
module boot_src_sel #(
  parameter int W = 8,
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          configured,
  input  logic          release_lock,
  input  logic [N-1:0]  in_valid,
  input  logic [N*W-1:0] in_data,
  output logic [N-1:0]  in_ready,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  input  logic          out_ready,
  output logic [IW-1:0] sel_idx,
  output logic          locked
);

  logic [IW-1:0] ptr;
  logic [IW-1:0] pick;
  logic          any_valid;
  logic          open_gate;

  assign any_valid = |in_valid;
  assign open_gate = locked && configured;

  always_comb begin
    pick = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (in_valid[(int'(ptr) + k) % N]) pick = IW'((int'(ptr) + k) % N);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      locked  <= 1'b0;
      sel_idx <= '0;
    end else begin
      ptr <= IW'((int'(ptr) + 1) % N);
      if (locked && release_lock) begin
        locked <= 1'b0;
      end else if (!locked && configured && any_valid) begin
        locked  <= 1'b1;
        sel_idx <= pick;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_rdy
    assign in_ready[g] = open_gate && (sel_idx == IW'(g)) && out_ready;
  end

  assign out_valid = open_gate && in_valid[sel_idx];
  assign out_data  = in_data[sel_idx*W +: W];

endmodule

// File: rtl/boot_src_sel_chk.sv
module boot_src_sel_chk #(
  parameter int N = 4,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          configured,
  input logic          release_lock,
  input logic [N-1:0]  in_valid,
  input logic [N-1:0]  in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [IW-1:0] sel_idx,
  input logic          locked
);

  assert_unconfigured_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !configured |-> (in_ready == '0) && !out_valid);

  assert_no_lock_unconfigured_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !locked && !configured |=> !locked);

  assert_lock_on_arrival_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !locked && configured && (in_valid != '0) |=> locked);

  assert_scan_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (in_ready == '0) && !out_valid);

  assert_pass_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |-> in_ready[sel_idx] && in_valid[sel_idx]);

  assert_single_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    locked && release_lock |=> !locked);

  assert_cfg_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !configured |-> !out_valid && (in_ready == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !release_lock |=> locked && $stable(sel_idx));

endmodule

bind boot_src_sel boot_src_sel_chk #(.N(N), .IW(IW)) i_chk (
  .clk(clk), .rst_n(rst_n), .configured(configured), .release_lock(release_lock),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .sel_idx(sel_idx), .locked(locked)
);

// File: tb/test_boot_src_sel.sv
`timescale 1ns/1ps
module test_boot_src_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg = 1'b0;
  logic        rel = 1'b0;
  logic [3:0]  vin = '0;
  logic [31:0] din = '0;
  logic [3:0]  rdy;
  logic        ov;
  logic [7:0]  od;
  logic        ordy = 1'b0;
  logic [1:0]  sel;
  logic        lck;

  int nchk = 0;
  int nerr = 0;
  int m_lock = 0;
  int m_sel = 0;
  int m_ptr = 0;
  string m_evt = "R9";

  always #2.5 clk = ~clk;

  boot_src_sel i_boot_src_sel (
    .clk(clk), .rst_n(rst_n), .configured(cfg), .release_lock(rel),
    .in_valid(vin), .in_data(din), .in_ready(rdy), .out_valid(ov),
    .out_data(od), .out_ready(ordy), .sel_idx(sel), .locked(lck)
  );

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit c, input bit r, input logic [3:0] v, input bit o);
    int erdy, eov;
    string tag;
    @(negedge clk);
    cfg = c; rel = r; vin = v; ordy = o;
    din = $urandom;
    #1;
    if (m_lock == 0) tag = c ? "R4" : "R2";
    else tag = c ? "R5" : "R8";
    erdy = (m_lock != 0 && c && o) ? (1 << m_sel) : 0;
    eov  = (m_lock != 0 && c && v[m_sel]) ? 1 : 0;
    if (m_lock != 0) check("R6", int'(rdy) & ~(1 << m_sel), 0);
    check(tag, int'(rdy), erdy);
    check(tag, int'(ov), eov);
    if (eov != 0) check("R5", int'(od), int'(din[m_sel*8 +: 8]));
    check(m_evt, int'(lck), m_lock);
    if (m_lock != 0) check(m_evt, int'(sel), m_sel);
    @(posedge clk);
    if (m_lock != 0 && r) begin
      m_lock = 0; m_evt = "R7";
    end else if (m_lock == 0 && c && v != 0) begin
      for (int k = 3; k >= 0; k--) if (v[(m_ptr + k) % 4]) m_sel = (m_ptr + k) % 4;
      m_lock = 1; m_evt = "R3";
    end else begin
      m_evt = (m_lock != 0) ? "R9" : "R7";
    end
    m_ptr = (m_ptr + 1) % 4;
  endtask

  initial begin
    #100us;
    nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    cfg = 1'b1; vin = 4'b1111; ordy = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R1", int'(lck), 0);
    check("R1", int'(sel), 0);
    check("R1", int'(ov), 0);
    check("R1", int'(rdy), 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R2: unconfigured, data waiting on several ports
    for (int i = 0; i < 6; i++) step(0, 0, 4'b1011, 1);
    // R3 R5 R6: lone arrival on position 2, others show data once locked
    step(1, 0, 4'b0100, 1);
    for (int i = 0; i < 12; i++) step(1, 0, 4'b1011 | (i[0] ? 4'b0100 : 4'b0000), i[1]);
    // R8: configured falls while locked
    for (int i = 0; i < 4; i++) step(0, 0, 4'b1111, 1);
    step(1, 0, 4'b0100, 1);
    // R7: release, then release while unlocked has no effect
    step(1, 1, 4'b0000, 1);
    for (int i = 0; i < 3; i++) step(1, 1, 4'b0000, 1);
    // R3: simultaneous arrivals at every pointer phase
    for (int ph = 0; ph < 8; ph++) begin
      for (int d = 0; d < ph % 4; d++) step(1, 0, 4'b0000, 0);
      step(1, 0, (ph < 4) ? 4'b1111 : 4'b1010, 1);
      step(1, 0, 4'b1111, 1);
      step(1, 1, 4'b1111, 1);
    end
    // R7 with arrival in the same cycle as release, then relock next edge
    step(1, 0, 4'b0001, 1);
    step(1, 1, 4'b1000, 1);
    step(1, 0, 4'b1000, 1);
    step(1, 0, 4'b1000, 0);
    // random mixture
    for (int i = 0; i < 500; i++)
      step(($urandom % 10) != 0, ($urandom % 16) == 0, 4'($urandom), 1'($urandom));

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule